// File: doc/BRIEF.md
# 64-bit Add/Subtract with Predicate Carry

This unit executes two wide arithmetic instructions that chain a carry through a predicate register: add-with-carry and subtract-with-carry. Each operation takes two 64-bit operands, which a register file supplies as register pairs, and an 8-bit predicate value. It returns a 64-bit result and a new predicate byte. The carry-in is the lowest bit of the predicate. The carry-out goes back into the same predicate as a full byte of ones or zeros, so a chain of these instructions can carry across operands wider than 64 bits.

Subtraction uses the same adder as addition, with the second operand inverted. The carry therefore means "no borrow", and a carry-in of 1 gives the exact difference. The unit decodes the operation from the major and minor opcode fields of the instruction. It also carries the predicate-register index and the destination-pair index along with the result, so that the writeback stage knows where the result goes. Operands are accepted with a valid strobe. The result is registered and appears one cycle later with its own valid.

Top module: `pcarry_alu`

## Requirements
- R1: When major field 0010 and minor field 110 are accepted, the result is A + B + c modulo 2^64. Here c is bit 0 of the input predicate, and predicate bits 7..1 have no effect.
- R2: When major field 0010 and minor field 111 are accepted, the result is A + ~B + c modulo 2^64, with c taken as in R1.
- R3: For both legal operations, the new predicate is 8'hFF when bit 64 of the 65-bit sum of zero-extended A, zero-extended B (or ~B) and c is set, and 8'h00 otherwise.
- R4: A subtract with c = 1 yields exactly A − B, and the new predicate is 8'hFF exactly when A ≥ B as unsigned numbers.
- R5: A request is legal only with major field 0010 and a minor field of 110 or 111. Any other field value sets out_illegal in the output cycle.
- R6: out_valid is in_valid delayed by one clock. A synchronous active-high reset clears out_valid, out_illegal, out_result, out_pred, out_psel and out_dst.
- R7: An illegal request yields out_result = 0, and out_pred equals the input predicate unchanged.
- R8: The 2-bit predicate index and the 5-bit destination-pair index of an accepted request appear on out_psel and out_dst with the same one-cycle latency.
- R9: While in_valid is low, out_result, out_pred, out_psel and out_dst keep their values, and out_illegal is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and fields are valid this cycle |
| in_major | input | 4 | Major opcode field |
| in_minor | input | 3 | Minor opcode field (110 add, 111 subtract) |
| in_a | input | 64 | First operand pair |
| in_b | input | 64 | Second operand pair |
| in_pred | input | 8 | Current predicate value |
| in_psel | input | 2 | Index of the predicate read and written |
| in_dst | input | 5 | Destination register-pair index |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | The accepted request had an unsupported opcode |
| out_result | output | 64 | Sum or difference |
| out_pred | output | 8 | New predicate value |
| out_psel | output | 2 | Predicate index carried with the result |
| out_dst | output | 5 | Destination index carried with the result |

## Verification
The bench tries the operations with boundary operands. All-ones plus zero with carry-in 1 must wrap to zero and set the predicate. Zero minus zero with carry-in 0 must give all ones with no carry; this separates A + ~B + c from a plain A − B. Subtracts with carry-in 1 at A > B, A = B and A < B show the no-borrow meaning of the carry. Predicates such as 8'hFE and 8'h01 separate a test of bit 0 from a test of the whole byte. Unsupported major and minor fields, idle gaps, a reset in the middle of a stream and a long run of random requests check the illegal path, the holding of outputs and the tag pass-through.

// File: rtl/pcarry_alu.sv
module pcarry_alu #(
  parameter int DW = 64,
  parameter int PW = 8,
  parameter int MAJW = 4,
  parameter int MINW = 3,
  parameter int PSW = 2,
  parameter int RDW = 5,
  parameter logic [MAJW-1:0] MAJ_SEL = 4'b0010,
  parameter logic [MINW-1:0] MIN_ADD = 3'b110,
  parameter logic [MINW-1:0] MIN_SUB = 3'b111
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [MAJW-1:0] in_major,
  input  logic [MINW-1:0] in_minor,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  input  logic [PW-1:0]   in_pred,
  input  logic [PSW-1:0]  in_psel,
  input  logic [RDW-1:0]  in_dst,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [DW-1:0]   out_result,
  output logic [PW-1:0]   out_pred,
  output logic [PSW-1:0]  out_psel,
  output logic [RDW-1:0]  out_dst
);

  logic          is_add, is_sub, legal;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;

  assign is_add = (in_major == MAJ_SEL) && (in_minor == MIN_ADD);
  assign is_sub = (in_major == MAJ_SEL) && (in_minor == MIN_SUB);
  assign legal  = is_add || is_sub;
  assign b_eff  = is_sub ? ~in_b : in_b;
  assign sum    = {1'b0, in_a} + {1'b0, b_eff} + {{DW{1'b0}}, in_pred[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_pred    <= '0;
      out_psel    <= '0;
      out_dst     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && !legal;
      if (in_valid) begin
        out_psel <= in_psel;
        out_dst  <= in_dst;
        if (legal) begin
          out_result <= sum[DW-1:0];
          out_pred   <= sum[DW] ? {PW{1'b1}} : {PW{1'b0}};
        end else begin
          out_result <= '0;
          out_pred   <= in_pred;
        end
      end
    end
  end

  a_r6_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r6_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r3_pred_byte: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal) |-> (out_pred == {PW{1'b1}} || out_pred == {PW{1'b0}}));
  a_r4_sub_exact: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_sub && in_pred[0]) |=> (out_result == $past(in_a) - $past(in_b)));
  a_r4_no_borrow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_sub && in_pred[0]) |=> ((out_pred == {PW{1'b1}}) == ($past(in_a) >= $past(in_b))));
  a_r7_illegal_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal) |=> (out_illegal && out_pred == $past(in_pred) && out_result == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_pred) && !out_illegal));
  a_r5_illegal_valid: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> out_valid);

endmodule

// File: tb/pcarry_alu_test.sv
module pcarry_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_major = '0;
  logic [2:0]  in_minor = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic [7:0]  in_pred = '0;
  logic [1:0]  in_psel = '0;
  logic [4:0]  in_dst = '0;
  logic        out_valid, out_illegal;
  logic [63:0] out_result;
  logic [7:0]  out_pred;
  logic [1:0]  out_psel;
  logic [4:0]  out_dst;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;
  string cur_req = "R6";

  logic        e_valid = 0, e_ill = 0;
  logic [63:0] e_res = 0;
  logic [7:0]  e_pred = 0;
  logic [1:0]  e_psel = 0;
  logic [4:0]  e_dst = 0;
  string       e_req = "R6";

  always #4 clk = ~clk;

  pcarry_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_major(in_major), .in_minor(in_minor),
    .in_a(in_a), .in_b(in_b), .in_pred(in_pred), .in_psel(in_psel), .in_dst(in_dst),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result),
    .out_pred(out_pred), .out_psel(out_psel), .out_dst(out_dst));

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      e_valid <= 0; e_ill <= 0; e_res <= 0; e_pred <= 0; e_psel <= 0; e_dst <= 0; e_req <= "R6";
    end else begin
      e_valid <= in_valid;
      e_ill <= 0;
      e_req <= in_valid ? cur_req : "R9";
      if (in_valid) begin
        e_psel <= in_psel;
        e_dst <= in_dst;
        if (in_major == 4'd2 && (in_minor == 3'd6 || in_minor == 3'd7)) begin
          logic [64:0] s;
          logic [63:0] bo;
          bo = (in_minor == 3'd7) ? ~in_b : in_b;
          s = 65'(in_a) + 65'(bo) + 65'(in_pred[0]);
          e_res <= s[63:0];
          e_pred <= s[64] ? 8'hFF : 8'h00;
        end else begin
          e_ill <= 1;
          e_res <= 0;
          e_pred <= in_pred;
        end
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("R6", 64'(out_valid), 64'(e_valid), "out_valid");
    chk("R5", 64'(out_illegal), 64'(e_ill), "out_illegal");
    chk(e_req, out_result, e_res, "out_result");
    chk(e_ill ? "R7" : (e_req == "R9" ? "R9" : "R3"), 64'(out_pred), 64'(e_pred), "out_pred");
    chk("R8", 64'(out_psel), 64'(e_psel), "out_psel");
    chk("R8", 64'(out_dst), 64'(e_dst), "out_dst");
  end

  task automatic op(logic [3:0] maj, logic [2:0] mn, logic [63:0] a, logic [63:0] b,
                    logic [7:0] p, logic [1:0] ps, logic [4:0] d, string req);
    @(negedge clk);
    in_valid = 1; in_major = maj; in_minor = mn; in_a = a; in_b = b;
    in_pred = p; in_psel = ps; in_dst = d; cur_req = req;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_a = {$urandom, $urandom}; in_b = ~in_a; in_pred = 8'h5A;
      in_psel = 2'd3; in_dst = 5'd31;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    op(4'd2, 3'd6, '1, 64'd0, 8'h01, 2'd1, 5'd4, "R1");
    op(4'd2, 3'd7, 64'd0, 64'd0, 8'h00, 2'd2, 5'd6, "R2");
    op(4'd2, 3'd6, '1, 64'd0, 8'hFE, 2'd0, 5'd8, "R1");
    op(4'd2, 3'd7, 64'd0, 64'd0, 8'hFE, 2'd3, 5'd10, "R2");
    op(4'd2, 3'd6, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h00, 2'd1, 5'd2, "R1");
    op(4'd2, 3'd7, 64'd100, 64'd7, 8'h01, 2'd0, 5'd0, "R4");
    op(4'd2, 3'd7, 64'd7, 64'd100, 8'h81, 2'd1, 5'd1, "R4");
    op(4'd2, 3'd7, 64'h1234, 64'h1234, 8'hFF, 2'd2, 5'd3, "R4");
    idle(3);
    op(4'd2, 3'd5, 64'd1, 64'd2, 8'hA5, 2'd3, 5'd9, "R7");
    op(4'd3, 3'd6, 64'd1, 64'd2, 8'h3C, 2'd0, 5'd11, "R7");
    op(4'd2, 3'd0, '1, '1, 8'hFE, 2'd1, 5'd13, "R7");
    idle(2);
    op(4'd2, 3'd6, 64'd5, 64'd6, 8'h01, 2'd2, 5'd14, "R1");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; in_valid = 0;
    idle(1);
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      m = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd6 : 3'd7);
      if ($urandom % 5 == 0) idle(1);
      op(($urandom % 8 == 0) ? 4'($urandom) : 4'd2, m,
         ($urandom % 6 == 0) ? '1 : {$urandom, $urandom},
         ($urandom % 6 == 0) ? '0 : {$urandom, $urandom},
         8'($urandom), 2'($urandom), 5'($urandom), (m == 3'd7) ? "R2" : "R1");
    end
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule